// File: doc/BRIEF.md
# Compare-and-Branch Next-PC Unit

This block works out the next program counter for the branch instructions of a small packet-filter CPU. It takes one instruction per cycle, qualified by `valid_i`. Each instruction brings the current PC, a 4-bit branch operation and a compare-width select. It also brings an operand-source select, the destination and source register values, a 32-bit immediate and a 16-bit signed offset. The block supports equality, unsigned ordering, signed ordering and bit-test conditions, plus an unconditional jump.

Instructions are 8 bytes long. A taken branch moves the PC by the offset plus one, counted in instructions. Everything else moves the PC to the next instruction. This covers a branch that is not taken, a subroutine call, a program exit and an undefined operation. The block does not carry out call or exit itself. It raises a one-cycle indication for each, so the surrounding pipeline can act on it. All outputs are registered and appear exactly one clock after the accepted input.

Top module: `br_pc_unit`

## Requirements
- R1: While `rst_ni` is low, `valid_o`, `taken_o`, `call_o`, `exit_o` and `next_pc_o` are all zero.
- R2: `valid_o` equals `valid_i` from the previous clock. When `valid_o` is low, `taken_o`, `call_o` and `exit_o` are low.
- R3: When a branch is taken, `next_pc_o` is the input PC plus (sign-extended `off_i` + 1) × 8, taken modulo 2^64.
- R4: When a valid instruction is not taken, `next_pc_o` is the input PC plus 8, taken modulo 2^64.
- R5: Operation 4'h0 (always) is taken regardless of its operands.
- R6: Operation 4'h1 is taken when the operands are equal. Operation 4'h5 is taken when they differ.
- R7: The unsigned operations are 4'h2 (greater), 4'h3 (greater or equal), 4'ha (less) and 4'hb (less or equal). Each compares destination against operand as unsigned numbers.
- R8: The signed operations are 4'h6 (greater), 4'h7 (greater or equal), 4'hc (less) and 4'hd (less or equal). Each compares as two's-complement numbers.
- R9: Operation 4'h4 is taken when the bitwise AND of destination and operand is nonzero.
- R10: With `wide_i` = 0, only bits 31:0 of both values take part in the compare, and bit 31 is the sign. With `wide_i` = 1, all 64 bits take part.
- R11: With `use_reg_i` = 0, the operand is `imm_i` sign-extended to 64 bits. With `use_reg_i` = 1, the operand is `src_val_i`.
- R12: Operation 4'h8 raises `call_o` and operation 4'h9 raises `exit_o`, each for that one output cycle. Neither sets `taken_o`, and both advance the PC by 8.
- R13: Operations 4'he and 4'hf are not taken and raise no indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction present this cycle |
| pc_i | input | 64 | Byte address of the instruction |
| op_i | input | 4 | Branch operation code |
| wide_i | input | 1 | 1: 64-bit compare, 0: 32-bit compare |
| use_reg_i | input | 1 | 1: operand is source register, 0: immediate |
| dst_val_i | input | 64 | Destination register value |
| src_val_i | input | 64 | Source register value |
| imm_i | input | 32 | Immediate |
| off_i | input | 16 | Signed branch offset in instructions |
| valid_o | output | 1 | Result present |
| next_pc_o | output | 64 | Next program counter |
| taken_o | output | 1 | Branch taken |
| call_o | output | 1 | Call indication |
| exit_o | output | 1 | Exit indication |

## Verification
The checks on the PC and on the indications assume a fixed relation between inputs and outputs. The inputs sampled on one edge must be the ones that the next edge's outputs describe. So `pc_i`, `op_i` and `off_i` are taken to be stable around each rising edge, and `valid_i` is taken to be low while reset is asserted. The stimulus keeps within these assumptions. It changes every input only on the falling edge, and it holds `valid_i` low until reset has been released. Operand patterns include equal values and values that differ only above bit 31. They also include sign-boundary values, so that both branch directions occur under each compare width.

// File: rtl/br_pkg.sv
package br_pkg;
  typedef enum logic [3:0] {
    OP_ALWAYS = 4'h0,
    OP_EQ     = 4'h1,
    OP_UGT    = 4'h2,
    OP_UGE    = 4'h3,
    OP_TEST   = 4'h4,
    OP_NE     = 4'h5,
    OP_SGT    = 4'h6,
    OP_SGE    = 4'h7,
    OP_CALL   = 4'h8,
    OP_EXIT   = 4'h9,
    OP_ULT    = 4'ha,
    OP_ULE    = 4'hb,
    OP_SLT    = 4'hc,
    OP_SLE    = 4'hd
  } br_op_e;

  typedef struct packed {
    logic eq;
    logic ult;
    logic slt;
    logic test;
  } br_flags_t;
endpackage

// File: rtl/br_operand_sel.sv
module br_operand_sel #(
  parameter int XLEN     = 64,
  parameter int NARROW_W = 32,
  parameter int IMM_W    = 32
) (
  input  logic            wide_i,
  input  logic            use_reg_i,
  input  logic [XLEN-1:0] dst_i,
  input  logic [XLEN-1:0] src_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [XLEN-1:0] lhs_o,
  output logic [XLEN-1:0] rhs_o,
  output logic [XLEN-1:0] sign_mask_o
);
  localparam logic [XLEN-1:0] SIGN_WIDE = {1'b1, {(XLEN-1){1'b0}}};

  logic [XLEN-1:0] imm_ext;
  logic [XLEN-1:0] rhs_full;

  assign imm_ext  = {{(XLEN-IMM_W){imm_i[IMM_W-1]}}, imm_i};
  assign rhs_full = use_reg_i ? src_i : imm_ext;

  generate
    if (XLEN > NARROW_W) begin : g_narrow
      localparam logic [XLEN-1:0] LOW_MASK    = {{(XLEN-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
      localparam logic [XLEN-1:0] SIGN_NARROW = {{(XLEN-NARROW_W){1'b0}}, 1'b1, {(NARROW_W-1){1'b0}}};
      // narrow compare: zero the upper bits, sign taken from bit NARROW_W-1
      assign lhs_o       = wide_i ? dst_i    : (dst_i & LOW_MASK);
      assign rhs_o       = wide_i ? rhs_full : (rhs_full & LOW_MASK);
      assign sign_mask_o = wide_i ? SIGN_WIDE : SIGN_NARROW;
    end else begin : g_full
      logic unused_wide;
      assign unused_wide = wide_i;
      assign lhs_o       = dst_i;
      assign rhs_o       = rhs_full;
      assign sign_mask_o = SIGN_WIDE;
    end
  endgenerate
endmodule

// File: rtl/br_cond_eval.sv
module br_cond_eval
  import br_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  br_op_e          op_i,
  input  logic [XLEN-1:0] lhs_i,
  input  logic [XLEN-1:0] rhs_i,
  input  logic [XLEN-1:0] sign_mask_i,
  output logic            cond_o
);
  br_flags_t fl;

  always_comb begin
    fl.eq   = (lhs_i == rhs_i);
    fl.ult  = (lhs_i < rhs_i);
    // flipping the sign bit turns a signed compare into an unsigned one
    fl.slt  = ((lhs_i ^ sign_mask_i) < (rhs_i ^ sign_mask_i));
    fl.test = |(lhs_i & rhs_i);
  end

  always_comb begin
    unique case (op_i)
      OP_ALWAYS: cond_o = 1'b1;
      OP_EQ:     cond_o = fl.eq;
      OP_NE:     cond_o = !fl.eq;
      OP_UGT:    cond_o = !fl.ult && !fl.eq;
      OP_UGE:    cond_o = !fl.ult;
      OP_ULT:    cond_o = fl.ult;
      OP_ULE:    cond_o = fl.ult || fl.eq;
      OP_SGT:    cond_o = !fl.slt && !fl.eq;
      OP_SGE:    cond_o = !fl.slt;
      OP_SLT:    cond_o = fl.slt;
      OP_SLE:    cond_o = fl.slt || fl.eq;
      OP_TEST:   cond_o = fl.test;
      default:   cond_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/br_target.sv
module br_target #(
  parameter int PC_W       = 64,
  parameter int OFF_W      = 16,
  parameter int INSN_BYTES = 8
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [PC_W-1:0]  seq_o,
  output logic [PC_W-1:0]  jump_o
);
  localparam int SHIFT = $clog2(INSN_BYTES);

  logic [PC_W-1:0] off_ext;

  assign off_ext = {{(PC_W-OFF_W){off_i[OFF_W-1]}}, off_i};
  assign seq_o   = pc_i + PC_W'(INSN_BYTES);
  assign jump_o  = pc_i + ((off_ext + PC_W'(1)) << SHIFT);
endmodule

// File: rtl/br_pc_unit.sv
module br_pc_unit
  import br_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int NARROW_W   = 32,
  parameter int IMM_W      = 32,
  parameter int OFF_W      = 16,
  parameter int INSN_BYTES = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [3:0]       op_i,
  input  logic             wide_i,
  input  logic             use_reg_i,
  input  logic [XLEN-1:0]  dst_val_i,
  input  logic [XLEN-1:0]  src_val_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [OFF_W-1:0] off_i,
  output logic             valid_o,
  output logic [XLEN-1:0]  next_pc_o,
  output logic             taken_o,
  output logic             call_o,
  output logic             exit_o
);
  br_op_e          op;
  logic [XLEN-1:0] lhs, rhs, sign_mask;
  logic [XLEN-1:0] seq_pc, jump_pc;
  logic            cond;

  assign op = br_op_e'(op_i);

  br_operand_sel #(.XLEN(XLEN), .NARROW_W(NARROW_W), .IMM_W(IMM_W)) u_sel (
    .wide_i      (wide_i),
    .use_reg_i   (use_reg_i),
    .dst_i       (dst_val_i),
    .src_i       (src_val_i),
    .imm_i       (imm_i),
    .lhs_o       (lhs),
    .rhs_o       (rhs),
    .sign_mask_o (sign_mask)
  );

  br_cond_eval #(.XLEN(XLEN)) u_cond (
    .op_i        (op),
    .lhs_i       (lhs),
    .rhs_i       (rhs),
    .sign_mask_i (sign_mask),
    .cond_o      (cond)
  );

  br_target #(.PC_W(XLEN), .OFF_W(OFF_W), .INSN_BYTES(INSN_BYTES)) u_tgt (
    .pc_i   (pc_i),
    .off_i  (off_i),
    .seq_o  (seq_pc),
    .jump_o (jump_pc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      taken_o   <= 1'b0;
      call_o    <= 1'b0;
      exit_o    <= 1'b0;
      next_pc_o <= '0;
    end else begin
      valid_o <= valid_i;
      taken_o <= valid_i && cond;
      call_o  <= valid_i && (op == OP_CALL);
      exit_o  <= valid_i && (op == OP_EXIT);
      if (valid_i) next_pc_o <= cond ? jump_pc : seq_pc;
    end
  end
endmodule

// File: rtl/br_pc_unit_chk.sv
module br_pc_unit_chk #(
  parameter int XLEN       = 64,
  parameter int OFF_W      = 16,
  parameter int INSN_BYTES = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [XLEN-1:0]  pc_i,
  input logic [3:0]       op_i,
  input logic [OFF_W-1:0] off_i,
  input logic             valid_o,
  input logic [XLEN-1:0]  next_pc_o,
  input logic             taken_o,
  input logic             call_o,
  input logic             exit_o
);
  localparam int SHIFT = $clog2(INSN_BYTES);

  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  // R2
  valid_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (valid_o == $past(valid_i)));

  // R2
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !(taken_o || call_o || exit_o));

  // R12
  flags_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({taken_o, call_o, exit_o}));

  // R4
  seq_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && valid_o && !taken_o) |-> (next_pc_o == $past(pc_i) + XLEN'(INSN_BYTES)));

  // R3
  jump_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && taken_o) |->
      (next_pc_o == $past(pc_i) +
        (({{(XLEN-OFF_W){$past(off_i[OFF_W-1])}}, $past(off_i)} + XLEN'(1)) << SHIFT)));

  // R5
  always_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(valid_i) && ($past(op_i) == 4'h0)) |-> taken_o);

  // R12
  call_ind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(valid_i)) |-> (call_o == ($past(op_i) == 4'h8)));

  // R13
  undef_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(valid_i) && ($past(op_i) >= 4'he)) |-> !(taken_o || call_o || exit_o));
endmodule

bind br_pc_unit br_pc_unit_chk #(.XLEN(XLEN), .OFF_W(OFF_W), .INSN_BYTES(INSN_BYTES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .pc_i      (pc_i),
  .op_i      (op_i),
  .off_i     (off_i),
  .valid_o   (valid_o),
  .next_pc_o (next_pc_o),
  .taken_o   (taken_o),
  .call_o    (call_o),
  .exit_o    (exit_o)
);

// File: tb/br_pc_unit_tb_top.sv
module br_pc_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [63:0] pc_i = '0;
  logic [3:0]  op_i = '0;
  logic        wide_i = 1'b0;
  logic        use_reg_i = 1'b0;
  logic [63:0] dst_val_i = '0;
  logic [63:0] src_val_i = '0;
  logic [31:0] imm_i = '0;
  logic [15:0] off_i = '0;
  logic        valid_o, taken_o, call_o, exit_o;
  logic [63:0] next_pc_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [63:0] npc;
    logic        tk;
    logic        cl;
    logic        ex;
    string       req;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  br_pc_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .pc_i(pc_i), .op_i(op_i),
    .wide_i(wide_i), .use_reg_i(use_reg_i), .dst_val_i(dst_val_i), .src_val_i(src_val_i),
    .imm_i(imm_i), .off_i(off_i), .valid_o(valid_o), .next_pc_o(next_pc_o),
    .taken_o(taken_o), .call_o(call_o), .exit_o(exit_o)
  );

  function automatic exp_t model(logic [63:0] pc, logic [3:0] op, logic wide, logic ureg,
                                 logic [63:0] d, logic [63:0] s, logic [31:0] imm,
                                 logic [15:0] off, string req);
    exp_t e;
    logic [63:0] b, ua, ub;
    logic signed [63:0] sa, sb;
    logic c;
    b = ureg ? s : {{32{imm[31]}}, imm};
    if (wide) begin
      ua = d; ub = b; sa = d; sb = b;
    end else begin
      ua = {32'h0, d[31:0]};
      ub = {32'h0, b[31:0]};
      sa = {{32{d[31]}}, d[31:0]};
      sb = {{32{b[31]}}, b[31:0]};
    end
    case (op)
      4'h0: c = 1'b1;
      4'h1: c = (ua == ub);
      4'h5: c = (ua != ub);
      4'h2: c = (ua > ub);
      4'h3: c = (ua >= ub);
      4'ha: c = (ua < ub);
      4'hb: c = (ua <= ub);
      4'h6: c = (sa > sb);
      4'h7: c = (sa >= sb);
      4'hc: c = (sa < sb);
      4'hd: c = (sa <= sb);
      4'h4: c = ((ua & ub) != 64'h0);
      default: c = 1'b0;
    endcase
    e.tk  = c;
    e.cl  = (op == 4'h8);
    e.ex  = (op == 4'h9);
    e.npc = c ? pc + 64'(($signed(off) + 64'sd1) * 64'sd8) : pc + 64'd8;
    e.req = req;
    return e;
  endfunction

  function automatic string req_of(logic [3:0] op);
    case (op)
      4'h0: return "R5";
      4'h1, 4'h5: return "R6";
      4'h2, 4'h3, 4'ha, 4'hb: return "R7";
      4'h6, 4'h7, 4'hc, 4'hd: return "R8";
      4'h4: return "R9";
      4'h8, 4'h9: return "R12";
      default: return "R13";
    endcase
  endfunction

  task automatic send(logic [63:0] pc, logic [3:0] op, logic wide, logic ureg,
                      logic [63:0] d, logic [63:0] s, logic [31:0] imm,
                      logic [15:0] off, string req);
    @(negedge clk);
    valid_i = 1'b1; pc_i = pc; op_i = op; wide_i = wide; use_reg_i = ureg;
    dst_val_i = d; src_val_i = s; imm_i = imm; off_i = off;
    q.push_back(model(pc, op, wide, ureg, d, s, imm, off, req));
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      valid_i = 1'b0;
      op_i = $urandom;
      pc_i = {$urandom, $urandom};
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        if (valid_o) begin
          if (q.size() == 0) begin
            total++; bad++;
            $display("FAIL R2: valid_o=1 expected=0 (nothing pending)");
          end else begin
            exp_t e;
            e = q.pop_front();
            total++;
            if (next_pc_o !== e.npc || taken_o !== e.tk || call_o !== e.cl || exit_o !== e.ex) begin
              bad++;
              $display("FAIL %s: npc=%h tk=%b call=%b exit=%b expected npc=%h tk=%b call=%b exit=%b",
                       e.req, next_pc_o, taken_o, call_o, exit_o, e.npc, e.tk, e.cl, e.ex);
            end
          end
        end else if (taken_o || call_o || exit_o) begin
          total++; bad++;
          $display("FAIL R2: idle flags tk=%b call=%b exit=%b expected 000", taken_o, call_o, exit_o);
        end
      end
    end
  end

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R2: watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    // R1 reset state
    if (valid_o !== 1'b0 || taken_o !== 1'b0 || call_o !== 1'b0 || exit_o !== 1'b0 || next_pc_o !== 64'h0) begin
      bad++;
      $display("FAIL R1: v=%b tk=%b cl=%b ex=%b npc=%h expected all zero",
               valid_o, taken_o, call_o, exit_o, next_pc_o);
    end
    rst_n = 1'b1;
    idle(2);

    // R5 always, R3 offsets incl. negative and zero and wrap
    send(64'h1000, 4'h0, 1, 0, 64'h0, 64'h0, 32'h0, 16'h0003, "R5");
    send(64'h1000, 4'h0, 1, 1, 64'h5, 64'h9, 32'h0, 16'hffff, "R3");
    send(64'h1000, 4'h0, 0, 0, 64'h0, 64'h0, 32'h0, 16'h8000, "R3");
    send(64'hffff_ffff_ffff_fff8, 4'h0, 1, 0, 64'h0, 64'h0, 32'h0, 16'h0000, "R3");
    send(64'hffff_ffff_ffff_fff8, 4'h1, 1, 1, 64'h1, 64'h2, 32'h0, 16'h0010, "R4");
    // R6 equality
    send(64'h2000, 4'h1, 1, 1, 64'hdead, 64'hdead, 32'h0, 16'h0004, "R6");
    send(64'h2000, 4'h5, 1, 1, 64'hdead, 64'hdead, 32'h0, 16'h0004, "R6");
    send(64'h2000, 4'h5, 1, 1, 64'hdead, 64'hbeef, 32'h0, 16'h7fff, "R6");
    // R11 immediate sign-extension
    send(64'h3000, 4'h1, 1, 0, 64'hffff_ffff_ffff_ffff, 64'h0, 32'hffff_ffff, 16'h0002, "R11");
    send(64'h3000, 4'h1, 1, 0, 64'h0000_0000_ffff_ffff, 64'h0, 32'hffff_ffff, 16'h0002, "R11");
    send(64'h3000, 4'h1, 1, 1, 64'h7, 64'h7, 32'h5, 16'h0002, "R11");
    // R10 narrow compare ignores upper bits
    send(64'h4000, 4'h1, 0, 1, 64'h1234_0000_0000_0005, 64'h9999_0000_0000_0005, 32'h0, 16'h0001, "R10");
    send(64'h4000, 4'h1, 1, 1, 64'h1234_0000_0000_0005, 64'h9999_0000_0000_0005, 32'h0, 16'h0001, "R10");
    send(64'h4000, 4'hc, 0, 0, 64'h0000_0000_8000_0000, 64'h0, 32'h1, 16'h0001, "R10");
    send(64'h4000, 4'hc, 1, 0, 64'h0000_0000_8000_0000, 64'h0, 32'h1, 16'h0001, "R10");
    // R7 unsigned vs R8 signed on sign boundary
    send(64'h5000, 4'h2, 1, 1, 64'h8000_0000_0000_0000, 64'h1, 32'h0, 16'h0005, "R7");
    send(64'h5000, 4'h6, 1, 1, 64'h8000_0000_0000_0000, 64'h1, 32'h0, 16'h0005, "R8");
    send(64'h5000, 4'h3, 1, 1, 64'h1, 64'h1, 32'h0, 16'h0005, "R7");
    send(64'h5000, 4'ha, 0, 1, 64'h1, 64'hffff_ffff, 32'h0, 16'h0005, "R7");
    send(64'h5000, 4'hb, 1, 1, 64'h2, 64'h1, 32'h0, 16'h0005, "R7");
    send(64'h5000, 4'h7, 0, 1, 64'hffff_ffff, 64'hffff_ffff, 32'h0, 16'hfff0, "R8");
    send(64'h5000, 4'hd, 0, 0, 64'h7fff_ffff, 64'h0, 32'h8000_0000, 16'hfff0, "R8");
    // R9 bit test
    send(64'h6000, 4'h4, 1, 0, 64'h10, 64'h0, 32'h0000_0010, 16'h0002, "R9");
    send(64'h6000, 4'h4, 1, 1, 64'h0f, 64'hf0, 32'h0, 16'h0002, "R9");
    send(64'h6000, 4'h4, 0, 1, 64'h1_0000_0000, 64'h1_0000_0000, 32'h0, 16'h0002, "R9");
    // R12 call/exit, R13 undefined
    send(64'h7000, 4'h8, 1, 0, 64'h0, 64'h0, 32'h0000_0005, 16'h0040, "R12");
    send(64'h7000, 4'h9, 1, 0, 64'h0, 64'h0, 32'h0, 16'h0040, "R12");
    send(64'h7000, 4'he, 1, 0, 64'h0, 64'h0, 32'h0, 16'h0040, "R13");
    send(64'h7000, 4'hf, 1, 1, 64'h3, 64'h3, 32'h0, 16'h0040, "R13");
    idle(3);

    // R2 gaps and random mix
    for (int i = 0; i < 600; i++) begin
      logic [3:0]  op;
      logic [63:0] d, s;
      logic [31:0] imm;
      op  = 4'($urandom);
      s   = {$urandom, $urandom};
      imm = $urandom;
      case ($urandom % 4)
        0: d = s;
        1: d = {{32{imm[31]}}, imm};
        2: d = {$urandom, s[31:0]};
        default: d = {$urandom, $urandom};
      endcase
      send({$urandom, $urandom}, op, 1'($urandom), 1'($urandom), d, s, imm, 16'($urandom), req_of(op));
      if ($urandom % 6 == 0) idle(1 + $urandom % 2);
    end
    idle(4);

    total++;
    if (q.size() != 0) begin
      bad++;
      $display("FAIL R2: pending=%0d expected=0", q.size());
    end
    done = 1'b1;
    finish_run();
  end
endmodule